// File: doc/BRIEF.md
# Accumulator Extract Unit

This unit takes one of several 64-bit signed accumulators and produces a 32-bit result from it. Each accumulator arrives as two 32-bit halves. The high half forms the upper 32 bits of a 64-bit signed value, and the low half, zero-extended, forms the lower 32 bits. That value is shifted right arithmetically by 0 to 31 places. The shifted value is then either kept as it is, rounded, rounded and clamped, or clamped to the signed 16-bit range. The choice depends on a 2-bit mode code.

A request is presented for one cycle with `req_valid`. The result appears on `res_data` after the next rising clock edge, and `res_valid` is high for that one cycle. When a result does not fit its target width, a sticky overflow flag is set. The flag is visible at bit 23 of a 32-bit status word and stays set until `ovf_clr` clears it.

A two-state controller sequences the unit.
- It has two states: `ST_IDLE` (no result is being presented) and `ST_EMIT` (a result is on `res_data`).
- `ST_IDLE -> ST_EMIT` happens on a valid request.
- `ST_EMIT -> ST_EMIT` happens when another request arrives back to back.
- `ST_EMIT -> ST_IDLE` happens when no request is present.
- Reset enters `ST_IDLE`.

Top module: `acx_extract`

## Requirements
- R1: The source value is `{hi, lo}` as a 64-bit signed number, where hi and lo are the 32-bit halves of accumulator `req_acc`. Accumulator k occupies bits `[32k+31:32k]` of `acc_hi_flat` and of `acc_lo_flat`.
- R2: The shift count is `req_rs[4:0]` when `req_use_reg` is 1 and `req_imm` otherwise. Bits 31..5 of `req_rs` are ignored, so counts range from 0 to 31.
- R3: In mode 0 (plain), the result is bits 31..0 of `source >>> shift`. Overflow is raised when that shifted value lies outside the signed 32-bit range.
- R4: In mode 1 (rounded), 2^(shift-1) is added to the source before the shift, using one extra bit of precision. A shift of 0 adds nothing. The result is the low 32 bits, and overflow is raised when the rounded value lies outside the signed 32-bit range.
- R5: Mode 2 (rounded, saturating) computes as mode 1. On overflow it returns 0x7FFFFFFF when the source is non-negative and 0x80000000 when the source is negative.
- R6: Mode 3 (16-bit saturating) takes `source >>> shift`. Values above 0x7FFF give 0x00007FFF, and values below -0x8000 give 0xFFFF8000; both raise overflow. In-range values are returned sign-extended to 32 bits.
- R7: Status bit 23 is a sticky overflow flag. All other status bits read 0. `ovf_clr` clears the flag, and an overflow in the same cycle as the clear wins.
- R8: After reset, `res_valid`, `res_data` and the status word are 0. Each request yields `res_valid` high for exactly the following cycle, with `res_data` loaded on that edge. Back-to-back requests give back-to-back results.
- R9: For hi=0x3FFFFFFF, lo=0x2BCDEF01 and shift 31, modes 0, 1 and 2 all return 0x7FFFFFFE without overflow. For hi=0x00000123, lo=0x87654321 and shift 28, mode 3 returns 0x00001238 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | 0 plain, 1 rounded, 2 rounded-saturating, 3 16-bit saturating |
| req_acc | input | 2 | Accumulator index |
| req_use_reg | input | 1 | 1: shift from `req_rs`, 0: from `req_imm` |
| req_imm | input | 5 | Immediate shift count |
| req_rs | input | 32 | Register operand; low five bits give the shift |
| acc_hi_flat | input | 128 | High halves of all accumulators |
| acc_lo_flat | input | 128 | Low halves of all accumulators |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| res_valid | output | 1 | Result strobe |
| res_data | output | 32 | Extracted result |
| ctl_status | output | 32 | Status word; bit 23 is sticky overflow |

## Verification
The checker assumes that `req_mode` stays stable and meaningful while `req_valid` is high. It also assumes that the accumulator halves are held steady across the cycle in which a request is sampled, so the previous cycle's mode explains the current result. The directed tasks drive every input on the falling edge and hold it for one full cycle. The random sweep obeys the same rule, and the accumulator contents are changed only between requests. Clear pulses are issued on their own or in deliberate overlap with an overflowing request, to exercise the set-over-clear priority.

// File: rtl/acx_pkg.sv
package acx_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_ROUND = 2'd1,
        MODE_RSAT  = 2'd2,
        MODE_SAT16 = 2'd3
    } acx_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } acx_state_e;

    localparam int CTL_W   = 32;
    localparam int OVF_BIT = 23;

endpackage

// File: rtl/acx_shifter.sv
module acx_shifter #(
    parameter int ACC_W = 64,
    parameter int SH_W  = 5
) (
    input  logic [ACC_W-1:0]        acc,
    input  logic [SH_W-1:0]         sh,
    input  logic                    round_en,
    output logic signed [ACC_W:0]   shifted
);
    localparam logic [ACC_W:0] ONE = {{ACC_W{1'b0}}, 1'b1};

    logic signed [ACC_W:0] ext;
    logic        [ACC_W:0] bias;
    logic signed [ACC_W:0] sum;

    // One guard bit above the source keeps the rounding add from wrapping.
    assign ext = $signed({acc[ACC_W-1], acc});

    always_comb begin
        bias = '0;
        if (round_en && (sh != '0)) begin
            bias = ONE << (sh - SH_W'(1));
        end
    end

    assign sum     = ext + $signed(bias);
    assign shifted = sum >>> sh;

endmodule

// File: rtl/acx_saturate.sv
module acx_saturate
    import acx_pkg::*;
#(
    parameter int ACC_W    = 64,
    parameter int OUT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  acx_mode_e               mode,
    input  logic signed [ACC_W:0]   shifted,
    input  logic                    src_neg,
    output logic [OUT_W-1:0]        result,
    output logic                    ovf
);
    localparam int WIDE_UP   = ACC_W - OUT_W + 2;
    localparam int NARROW_UP = ACC_W - NARROW_W + 2;

    localparam logic [OUT_W-1:0] WIDE_MAX   = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] WIDE_MIN   = {1'b1, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] NARROW_MAX = {{(OUT_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NARROW_MIN = {{(OUT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    logic [WIDE_UP-1:0]   wide_top;
    logic [NARROW_UP-1:0] narrow_top;
    logic                 wide_fits;
    logic                 narrow_fits;
    logic                 val_neg;
    logic [OUT_W-1:0]     narrow_ext;

    assign wide_top    = shifted[ACC_W:OUT_W-1];
    assign narrow_top  = shifted[ACC_W:NARROW_W-1];
    assign wide_fits   = (wide_top == '0) || (wide_top == '1);
    assign narrow_fits = (narrow_top == '0) || (narrow_top == '1);
    assign val_neg     = shifted[ACC_W];
    assign narrow_ext  = {{(OUT_W-NARROW_W){shifted[NARROW_W-1]}}, shifted[NARROW_W-1:0]};

    always_comb begin
        result = shifted[OUT_W-1:0];
        ovf    = 1'b0;
        unique case (mode)
            MODE_PLAIN, MODE_ROUND: begin
                ovf = !wide_fits;
            end
            MODE_RSAT: begin
                ovf = !wide_fits;
                if (!wide_fits) begin
                    result = src_neg ? WIDE_MIN : WIDE_MAX;
                end
            end
            MODE_SAT16: begin
                ovf    = !narrow_fits;
                result = narrow_ext;
                if (!narrow_fits) begin
                    result = val_neg ? NARROW_MIN : NARROW_MAX;
                end
            end
        endcase
    end

endmodule

// File: rtl/acx_extract.sv
module acx_extract
    import acx_pkg::*;
#(
    parameter int HALF_W   = 32,
    parameter int NUM_ACC  = 4,
    parameter int NARROW_W = 16,
    localparam int SEL_W   = $clog2(NUM_ACC),
    localparam int SH_W    = $clog2(HALF_W),
    localparam int ACC_W   = 2 * HALF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_mode,
    input  logic [SEL_W-1:0]          req_acc,
    input  logic                      req_use_reg,
    input  logic [SH_W-1:0]           req_imm,
    input  logic [HALF_W-1:0]         req_rs,
    input  logic [NUM_ACC*HALF_W-1:0] acc_hi_flat,
    input  logic [NUM_ACC*HALF_W-1:0] acc_lo_flat,
    input  logic                      ovf_clr,
    output logic                      res_valid,
    output logic [HALF_W-1:0]         res_data,
    output logic [CTL_W-1:0]          ctl_status
);
    acx_mode_e             mode_w;
    logic [ACC_W-1:0]      acc_arr [NUM_ACC];
    logic [ACC_W-1:0]      acc_sel;
    logic [SH_W-1:0]       shift_amt;
    logic                  round_en;
    logic signed [ACC_W:0] shifted;
    logic [HALF_W-1:0]     res_next;
    logic                  ovf_next;
    logic [HALF_W-SH_W-1:0] unused_rs_hi;

    acx_state_e        state_q, state_d;
    logic [HALF_W-1:0] res_q;
    logic              ovf_q;

    assign mode_w = acx_mode_e'(req_mode);

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        assign acc_arr[g] = {acc_hi_flat[g*HALF_W +: HALF_W], acc_lo_flat[g*HALF_W +: HALF_W]};
    end

    assign acc_sel      = acc_arr[req_acc];
    assign shift_amt    = req_use_reg ? req_rs[SH_W-1:0] : req_imm;
    assign unused_rs_hi = req_rs[HALF_W-1:SH_W];
    assign round_en     = (mode_w == MODE_ROUND) || (mode_w == MODE_RSAT);

    acx_shifter #(
        .ACC_W (ACC_W),
        .SH_W  (SH_W)
    ) u_shift (
        .acc      (acc_sel),
        .sh       (shift_amt),
        .round_en (round_en),
        .shifted  (shifted)
    );

    acx_saturate #(
        .ACC_W    (ACC_W),
        .OUT_W    (HALF_W),
        .NARROW_W (NARROW_W)
    ) u_sat (
        .mode    (mode_w),
        .shifted (shifted),
        .src_neg (acc_sel[ACC_W-1]),
        .result  (res_next),
        .ovf     (ovf_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        res_valid           = (state_q == ST_EMIT);
        res_data            = res_q;
        ctl_status          = '0;
        ctl_status[OVF_BIT] = ovf_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (req_valid) begin
            res_q <= res_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (req_valid && ovf_next) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

endmodule

// File: rtl/acx_extract_chk.sv
module acx_extract_chk
    import acx_pkg::*;
#(
    parameter int HALF_W   = 32,
    parameter int NARROW_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_mode,
    input logic              ovf_clr,
    input logic              res_valid,
    input logic [HALF_W-1:0] res_data,
    input logic [CTL_W-1:0]  ctl_status
);
    localparam logic [CTL_W-1:0]  OVF_MASK = CTL_W'(1) << OVF_BIT;
    localparam logic [HALF_W-1:0] SMAX     = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] SMIN     = {1'b1, {(HALF_W-1){1'b0}}};

    logic [HALF_W-NARROW_W:0] res_top;
    assign res_top = res_data[HALF_W-1:NARROW_W-1];

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid) else $error("R8 missing result strobe");

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid) else $error("R8 spurious result strobe");

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_status[OVF_BIT] && !ovf_clr) |=> ctl_status[OVF_BIT]) else $error("R7 flag dropped");

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_status & ~OVF_MASK) == '0) else $error("R7 reserved bits set");

    assert_narrow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_mode) == 2'd3) |-> ((res_top == '0) || (res_top == '1)))
        else $error("R6 result out of 16-bit range");

    assert_sat_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_mode) == 2'd2 && $rose(ctl_status[OVF_BIT]))
        |-> (res_data == SMAX || res_data == SMIN)) else $error("R5 unclamped overflow");

endmodule

bind acx_extract acx_extract_chk #(
    .HALF_W   (HALF_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .ovf_clr    (ovf_clr),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .ctl_status (ctl_status)
);

// File: tb/acx_extract_test.sv
module acx_extract_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [1:0]   req_mode;
    logic [1:0]   req_acc;
    logic         req_use_reg;
    logic [4:0]   req_imm;
    logic [31:0]  req_rs;
    logic [127:0] acc_hi_flat;
    logic [127:0] acc_lo_flat;
    logic         ovf_clr;
    logic         res_valid;
    logic [31:0]  res_data;
    logic [31:0]  ctl_status;

    int  total = 0;
    int  bad   = 0;
    bit  exp_sticky = 1'b0;
    bit  done = 1'b0;
    logic [31:0] hi_m [4];
    logic [31:0] lo_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    acx_extract uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_acc(req_acc), .req_use_reg(req_use_reg), .req_imm(req_imm),
        .req_rs(req_rs), .acc_hi_flat(acc_hi_flat), .acc_lo_flat(acc_lo_flat),
        .ovf_clr(ovf_clr), .res_valid(res_valid), .res_data(res_data),
        .ctl_status(ctl_status)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Reference computed straight from R3..R6
    function automatic void model(input int mode, input logic [31:0] hi, input logic [31:0] lo,
                                  input int sh, output logic [31:0] r, output bit ov);
        logic signed [64:0] t;
        logic signed [64:0] a;
        a = $signed({hi[31], hi, lo});
        if ((mode == 1 || mode == 2) && sh != 0) begin
            t = a >>> (sh - 1);
            t = (t + 65'sd1) >>> 1;
        end else begin
            t = a >>> sh;
        end
        r  = t[31:0];
        ov = 1'b0;
        if (mode == 3) begin
            if (t > 65'sd32767) begin r = 32'h0000_7FFF; ov = 1'b1; end
            else if (t < -65'sd32768) begin r = 32'hFFFF_8000; ov = 1'b1; end
        end else begin
            ov = (t > 65'sd2147483647) || (t < -65'sd2147483648);
            if (mode == 2 && ov) r = hi[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end
    endfunction

    task automatic set_acc(input int k, input logic [31:0] hi, input logic [31:0] lo);
        hi_m[k] = hi;
        lo_m[k] = lo;
        acc_hi_flat[k*32 +: 32] = hi;
        acc_lo_flat[k*32 +: 32] = lo;
    endtask

    // Drive one request at a falling edge; check one cycle later
    task automatic do_op(input string req, input int mode, input int k, input bit use_reg,
                         input logic [4:0] imm, input logic [31:0] rs, input bit clr,
                         input bit use_fixed, input logic [31:0] fixed_exp);
        logic [31:0] er;
        bit          eo;
        int          sh;
        @(negedge clk);
        sh = use_reg ? int'(rs[4:0]) : int'(imm);
        model(mode, hi_m[k], lo_m[k], sh, er, eo);
        if (use_fixed) er = fixed_exp;
        req_valid = 1'b1; req_mode = 2'(mode); req_acc = 2'(k);
        req_use_reg = use_reg; req_imm = imm; req_rs = rs; ovf_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; ovf_clr = 1'b0;
        exp_sticky = (clr && !eo) ? 1'b0 : (exp_sticky | eo);
        check({req, " R8 strobe"}, {31'd0, res_valid}, 32'd1);
        check({req, " data"}, res_data, er);
        check({req, " R7 status"}, ctl_status, {8'd0, exp_sticky, 23'd0});
    endtask

    task automatic clear_flag();
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        exp_sticky = 1'b0;
        check("R7 clear", ctl_status, 32'd0);
        check("R8 idle after op", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R8 reset valid", {31'd0, res_valid}, 32'd0);
        check("R8 reset data", res_data, 32'd0);
        check("R8 reset status", ctl_status, 32'd0);
    endtask

    task automatic t_known_vectors(); // R9
        set_acc(1, 32'h3FFF_FFFF, 32'h2BCD_EF01);
        do_op("R9 R3 plain imm", 0, 1, 1'b0, 5'd31, 32'd0, 1'b0, 1'b1, 32'h7FFF_FFFE);
        do_op("R9 R4 round reg", 1, 1, 1'b1, 5'd0, 32'd31, 1'b0, 1'b1, 32'h7FFF_FFFE);
        do_op("R9 R5 rsat imm", 2, 1, 1'b0, 5'd31, 32'd0, 1'b0, 1'b1, 32'h7FFF_FFFE);
        set_acc(1, 32'h0000_0123, 32'h8765_4321);
        do_op("R9 R6 sat16 imm", 3, 1, 1'b0, 5'd28, 32'd0, 1'b0, 1'b1, 32'h0000_1238);
        do_op("R9 R6 sat16 reg", 3, 1, 1'b1, 5'd0, 32'h1C, 1'b0, 1'b1, 32'h0000_1238);
    endtask

    task automatic t_shift_mask(); // R2: upper operand bits ignored
        set_acc(2, 32'h3FFF_FFFF, 32'h2BCD_EF01);
        do_op("R2 rs=FFFFFFFF", 0, 2, 1'b1, 5'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h7FFF_FFFE);
        set_acc(2, 32'h0000_0000, 32'h0000_0100);
        do_op("R2 rs=FFFFFFE4", 0, 2, 1'b1, 5'd0, 32'hFFFF_FFE4, 1'b0, 1'b1, 32'h0000_0010);
        do_op("R2 imm used when reg off", 0, 2, 1'b0, 5'd8, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0000_0001);
    endtask

    task automatic t_plain_overflow(); // R3, R7
        set_acc(0, 32'h1234_5678, 32'h0000_0000);
        do_op("R3 plain ovf", 0, 0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'h0000_0000);
        set_acc(0, 32'h0000_0000, 32'h0000_0004);
        do_op("R7 flag stays", 0, 0, 1'b0, 5'd1, 32'd0, 1'b0, 1'b1, 32'h0000_0002);
        clear_flag();
        set_acc(0, 32'hFFFF_FFFF, 32'h8000_0000);
        do_op("R3 min fits", 0, 0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'h8000_0000);
    endtask

    task automatic t_rounding(); // R4
        set_acc(3, 32'h0000_0000, 32'h0000_0003);
        do_op("R4 round up", 1, 3, 1'b0, 5'd1, 32'd0, 1'b0, 1'b1, 32'h0000_0002);
        do_op("R3 no round", 0, 3, 1'b0, 5'd1, 32'd0, 1'b0, 1'b1, 32'h0000_0001);
        set_acc(3, 32'h0000_0000, 32'h0000_0005);
        do_op("R4 shift zero", 1, 3, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'h0000_0005);
        set_acc(3, 32'hFFFF_FFFF, 32'hFFFF_FFFB);
        do_op("R4 negative", 1, 3, 1'b0, 5'd2, 32'd0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        set_acc(3, 32'h3FFF_FFFF, 32'hFFFF_FFFF);
        do_op("R4 round pushes ovf", 1, 3, 1'b0, 5'd31, 32'd0, 1'b0, 1'b1, 32'h8000_0000);
        clear_flag();
    endtask

    task automatic t_sat32(); // R5
        set_acc(0, 32'h7FFF_FFFF, 32'h0000_0000);
        do_op("R5 pos clamp", 2, 0, 1'b0, 5'd4, 32'd0, 1'b0, 1'b1, 32'h7FFF_FFFF);
        clear_flag();
        set_acc(0, 32'h8000_0000, 32'h0000_0000);
        do_op("R5 neg clamp", 2, 0, 1'b0, 5'd4, 32'd0, 1'b0, 1'b1, 32'h8000_0000);
        do_op("R4 wraps unclamped", 1, 0, 1'b0, 5'd4, 32'd0, 1'b0, 1'b1, 32'h0000_0000);
        clear_flag();
    endtask

    task automatic t_sat16(); // R6
        set_acc(1, 32'hFFFF_FFFF, 32'h8000_0000);
        do_op("R6 neg clamp", 3, 1, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'hFFFF_8000);
        clear_flag();
        set_acc(1, 32'h0000_0001, 32'h0000_0000);
        do_op("R6 pos clamp", 3, 1, 1'b0, 5'd16, 32'd0, 1'b0, 1'b1, 32'h0000_7FFF);
        clear_flag();
        set_acc(1, 32'hFFFF_FFFF, 32'hFFFF_FF00);
        do_op("R6 in range neg", 3, 1, 1'b0, 5'd4, 32'd0, 1'b0, 1'b1, 32'hFFFF_FFF0);
        set_acc(1, 32'h0000_0000, 32'h0000_8000);
        do_op("R6 edge pos", 3, 1, 1'b0, 5'd1, 32'd0, 1'b0, 1'b1, 32'h0000_4000);
    endtask

    task automatic t_select(); // R1
        set_acc(0, 32'h0, 32'h0000_0011);
        set_acc(1, 32'h0, 32'h0000_0022);
        set_acc(2, 32'h0, 32'h0000_0033);
        set_acc(3, 32'h0, 32'h0000_0044);
        do_op("R1 acc0", 0, 0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'h11);
        do_op("R1 acc3", 0, 3, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'h44);
        do_op("R1 acc2", 0, 2, 1'b0, 5'd0, 32'd0, 1'b0, 1'b1, 32'h33);
        set_acc(1, 32'h0000_0001, 32'h0000_0000);
        do_op("R1 hi placement", 0, 1, 1'b0, 5'd4, 32'd0, 1'b0, 1'b1, 32'h1000_0000);
    endtask

    task automatic t_set_beats_clear(); // R7
        set_acc(2, 32'h7FFF_FFFF, 32'h0);
        do_op("R7 set over clear", 0, 2, 1'b0, 5'd0, 32'd0, 1'b1, 1'b1, 32'h0);
        clear_flag();
    endtask

    task automatic t_back_to_back(); // R8
        set_acc(0, 32'h0, 32'h0000_0100);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 2'd0; req_acc = 2'd0; req_use_reg = 1'b0; req_imm = 5'd4;
        @(negedge clk);
        check("R8 b2b first", res_data, 32'h10);
        check("R8 b2b strobe1", {31'd0, res_valid}, 32'd1);
        req_imm = 5'd8;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 b2b second", res_data, 32'h1);
        check("R8 b2b strobe2", {31'd0, res_valid}, 32'd1);
        @(negedge clk);
        check("R8 strobe drops", {31'd0, res_valid}, 32'd0);
        check("R8 data held", res_data, 32'h1);
    endtask

    task automatic t_random(); // R1..R6 against the model
        for (int i = 0; i < 200; i++) begin
            for (int k = 0; k < 4; k++) set_acc(k, $urandom, $urandom);
            do_op("R3-R6 random", int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  1'($urandom), 5'($urandom), $urandom, 1'b0, 1'b0, 32'd0);
            if (exp_sticky) clear_flag();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R8 got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_acc = 2'd0;
        req_use_reg = 1'b0; req_imm = 5'd0; req_rs = 32'd0; ovf_clr = 1'b0;
        acc_hi_flat = '0; acc_lo_flat = '0;
        for (int k = 0; k < 4; k++) begin hi_m[k] = '0; lo_m[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known_vectors();
        t_shift_mask();
        t_plain_overflow();
        t_rounding();
        t_sat32();
        t_sat16();
        t_select();
        t_set_beats_clear();
        t_back_to_back();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule